// File: doc/BRIEF.md
# Display Identity Stream Transmitter

This block sends the contents of a 128-byte display identity memory as an endless serial stream on an open-drain data line. There is no handshake and no addressing from the receiver. The receiver supplies a slow stream clock that is normally derived from vertical sync. The block samples that clock in the system clock domain and sends one bit for each rising edge.

Each frame carries one memory byte, most significant bit first, followed by a ninth null bit. After the last byte the stream returns to the first byte and continues without end. The block reads each byte from a synchronous memory port one cycle after it issues the address. It keeps the next byte ready before the bit that needs it.

After reset the line stays released for a synchronisation window of nine stream clock edges. A separate mode controller drives two inputs. An enable input pauses the stream: while it is low the line is released and the stream stops. A restart pulse makes the next stream edge begin again at address 0.

Top module: `edid_stream_tx`

## Requirements
- R1: The eight data bits of each frame go out most significant bit first. A data bit of 0 pulls the line low (`lineOe` = 1) and a data bit of 1 releases it (`lineOe` = 0).
- R2: The ninth bit of every frame is a null bit and is sent by releasing the line.
- R3: Each rising edge of `streamClk` advances the stream by exactly one bit. The line level changes only after a stream clock rising edge or a restart pulse.
- R4: After reset the line stays released for the first nine stream clock rising edges. The tenth rising edge presents the most significant bit of the byte at address 0.
- R5: Frames carry bytes at consecutive addresses. After address 127 the stream continues at address 0.
- R6: A one-cycle `restart` pulse releases the line and skips any remaining synchronisation window. The next stream clock rising edge presents the most significant bit of address 0, and the cycle after the pulse reads address 0.
- R7: While `enable` is low the line is released and stream clock edges are ignored. When `enable` returns high the stream resumes at the bit position where it stopped.
- R8: `memRdEn` is a one-cycle pulse. A read is issued once after reset, once after each restart and once per frame. No read is issued while `enable` is low unless a restart occurs.
- R9: During and just after reset the line is released and the read address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| streamClk | input | 1 | Slow stream clock from the receiver, asynchronous to clk |
| enable | input | 1 | Stream enable from the mode controller |
| restart | input | 1 | One-cycle pulse: restart the stream at address 0 |
| memRdEn | output | 1 | Read strobe to the identity memory |
| memAddr | output | 7 | Read address to the identity memory |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| lineOe | output | 1 | Open-drain pull-down enable for the data line (1 = pull low) |

## Verification
The assertions assume three things about the inputs. First, `streamClk` is far slower than `clk`, so that only one stream edge is in flight at a time. Second, `restart` is a single-cycle pulse that never arrives in the same few cycles as a stream edge. Third, `enable` changes only between stream edges. The stimulus keeps every `streamClk` level for several system cycles and changes `enable` and `restart` only during the low phase of the stream clock. The memory model answers one cycle after each read strobe, which matches the latency the datapath expects.

// File: rtl/edid_ser_pkg.sv
package edid_ser_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic loadByte;     // present MSB of the prefetched byte, advance address
    logic shiftBit;     // present the next data bit
    logic nullBit;      // present the released ninth bit
    logic restartAddr;  // point the fetch address at zero, release line
    logic fetch;        // issue a memory read at the fetch address
  } serStrobe_t;

endpackage

// File: rtl/stream_rise_det.sv
module stream_rise_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic streamClk,
  output logic streamRise
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], streamClk};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign streamRise = syncQ[SYNC_STAGES-1] & ~prevQ;

endmodule

// File: rtl/edid_ser_ctrl.sv
module edid_ser_ctrl
  import edid_ser_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int WARMUP_EDGES = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       streamRise,
  input  logic       enable,
  input  logic       restart,
  output serStrobe_t strobe,
  output logic       warmDone
);

  localparam int POS_W  = $clog2(DATA_W + 1);
  localparam int WARM_W = $clog2(WARMUP_EDGES + 1);
  localparam logic [POS_W-1:0]  NULL_POS  = POS_W'(DATA_W);
  localparam logic [POS_W-1:0]  LAST_DATA = POS_W'(DATA_W - 1);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARMUP_EDGES - 1);

  logic [POS_W-1:0]  bitPos;   // index of the bit now on the line
  logic [WARM_W-1:0] warmCnt;
  logic              fetchQ;
  logic              step;

  assign step = streamRise & enable;

  always_comb begin
    strobe       = '0;
    strobe.fetch = fetchQ;
    if (restart) begin
      strobe.restartAddr = 1'b1;
    end else if (step && warmDone) begin
      if (bitPos == NULL_POS)       strobe.loadByte = 1'b1;
      else if (bitPos == LAST_DATA) strobe.nullBit  = 1'b1;
      else                          strobe.shiftBit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos   <= NULL_POS;
      warmCnt  <= '0;
      warmDone <= 1'b0;
      fetchQ   <= 1'b1;   // prefetch address 0 right after reset
    end else begin
      fetchQ <= strobe.loadByte | strobe.restartAddr;
      if (restart) begin
        warmDone <= 1'b1;
        bitPos   <= NULL_POS;
      end else if (step) begin
        if (!warmDone) begin
          if (warmCnt == WARM_LAST) warmDone <= 1'b1;
          else                      warmCnt  <= warmCnt + 1'b1;
        end else if (bitPos == NULL_POS) begin
          bitPos <= '0;
        end else begin
          bitPos <= bitPos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/edid_ser_dp.sv
module edid_ser_dp
  import edid_ser_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              bitOut
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] fetchAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              rdValid;
  logic [DATA_W-1:0] bufByte;
  logic [DATA_W-1:0] shiftReg;

  assign nextAddr = (fetchAddr == LAST_ADDR) ? '0 : fetchAddr + 1'b1;
  assign memRdEn  = strobe.fetch;
  assign memAddr  = fetchAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
      rdValid   <= 1'b0;
      bufByte   <= '0;
      shiftReg  <= '0;
      bitOut    <= 1'b1;
    end else begin
      rdValid <= strobe.fetch;
      if (rdValid) bufByte <= memRdData;
      if (strobe.restartAddr) begin
        fetchAddr <= '0;
        bitOut    <= 1'b1;
      end else if (strobe.loadByte) begin
        bitOut    <= bufByte[DATA_W-1];
        shiftReg  <= bufByte << 1;
        fetchAddr <= nextAddr;
      end else if (strobe.shiftBit) begin
        bitOut   <= shiftReg[DATA_W-1];
        shiftReg <= shiftReg << 1;
      end else if (strobe.nullBit) begin
        bitOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/edid_stream_tx.sv
module edid_stream_tx
  import edid_ser_pkg::*;
#(
  parameter  int DEPTH        = 128,
  parameter  int DATA_W       = 8,
  parameter  int WARMUP_EDGES = 9,
  parameter  int SYNC_STAGES  = 2,
  localparam int ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              streamClk,
  input  logic              enable,
  input  logic              restart,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              lineOe
);

  logic       streamRise;
  logic       warmDone;
  logic       bitOut;
  serStrobe_t strobe;

  stream_rise_det #(.SYNC_STAGES(SYNC_STAGES)) riseDet (
    .clk(clk), .rstN(rstN), .streamClk(streamClk), .streamRise(streamRise)
  );

  edid_ser_ctrl #(.DATA_W(DATA_W), .WARMUP_EDGES(WARMUP_EDGES)) ctrl (
    .clk(clk), .rstN(rstN), .streamRise(streamRise), .enable(enable),
    .restart(restart), .strobe(strobe), .warmDone(warmDone)
  );

  edid_ser_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .memRdEn(memRdEn), .memAddr(memAddr), .bitOut(bitOut)
  );

  assign lineOe = enable & warmDone & ~bitOut;

endmodule

// File: rtl/edid_stream_tx_chk.sv
module edid_stream_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              restart,
  input logic              streamRise,
  input logic              warmDone,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              lineOe
);

  // R3: a line change with enable steady follows a stream edge or a restart
  p_change_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(lineOe)) |-> ($past(streamRise) || $past(restart)));

  // R4: the synchronisation window ends only on a stream edge unless restarted
  p_warm_end_on_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(warmDone) && !$past(restart)) |-> $past(streamRise));

  // R6: a restart is followed by a read of address zero
  p_restart_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (memRdEn && memAddr == '0));

  // R7: no frame advance (and hence no read) while disabled
  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !restart) |=> !memRdEn);

  // R8: read strobe lasts one cycle
  p_single_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

endmodule

bind edid_stream_tx edid_stream_tx_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk(clk), .rstN(rstN), .enable(enable), .restart(restart),
  .streamRise(streamRise), .warmDone(warmDone), .memRdEn(memRdEn),
  .memAddr(memAddr), .lineOe(lineOe)
);

// File: tb/edid_stream_tx_test.sv
`timescale 1ns/1ps
module edid_stream_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       streamClk = 1'b0;
  logic       enable = 1'b1;
  logic       restart = 1'b0;
  logic       memRdEn;
  logic [6:0] memAddr;
  logic [7:0] memRdData = '0;
  logic       lineOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edid_stream_tx uut (
    .clk(clk), .rstN(rstN), .streamClk(streamClk), .enable(enable),
    .restart(restart), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .lineOe(lineOe)
  );

  function automatic logic [7:0] memByte(input int a);
    return 8'(a * 29 + 17);
  endfunction

  always_ff @(posedge clk) if (memRdEn) memRdData <= memByte(int'(memAddr));

  // expected line levels (1 = released) for the first two frames: 0x11, null, 0x2E, null
  localparam bit EXP_LVL [18] = '{0,0,0,1,0,0,0,1,1, 0,0,1,0,1,1,1,0,1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(output logic lvl);
    streamClk = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    lvl = !lineOe;
    streamClk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic getFrame(output logic [7:0] d, output logic nul);
    logic l;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(l);
      d = {d[6:0], l};
    end
    tick(nul);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!lineOe && memAddr == 7'd0, "R9", {lineOe, memAddr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!lineOe && memAddr == 7'd0, "R9", {lineOe, memAddr}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic l, nul;
    logic [7:0] d;
    doReset();

    // R4: nine edges of released line
    for (int i = 0; i < 9; i++) begin
      tick(l);
      check(l == 1'b1, "R4 warmup", l, 1);
    end

    // R1 R2 R3: table of the first two frames
    for (int i = 0; i < 18; i++) begin
      tick(l);
      check(l == EXP_LVL[i], "R1/R2/R3 table", l, EXP_LVL[i]);
    end

    // R5: remaining frames through the wrap back to address 0 and 1
    for (int idx = 2; idx < 130; idx++) begin
      getFrame(d, nul);
      check(d == memByte(idx % 128), "R5 sequence", d, memByte(idx % 128));
      check(nul == 1'b1, "R2 null", nul, 1);
    end

    // R7: pause in the middle of address 2
    d = '0;
    for (int i = 0; i < 3; i++) begin tick(l); d = {d[6:0], l}; end
    enable = 1'b0;
    @(negedge clk);
    check(!lineOe, "R7 released", lineOe, 0);
    for (int i = 0; i < 4; i++) begin
      tick(l);
      check(l == 1'b1, "R7 ignored edge", l, 1);
    end
    enable = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin tick(l); d = {d[6:0], l}; end
    tick(nul);
    check(d == memByte(2) && nul, "R7 resume", d, memByte(2));

    // R6: restart in the middle of address 3
    for (int i = 0; i < 4; i++) tick(l);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    @(negedge clk);
    check(!lineOe, "R6 released", lineOe, 0);
    getFrame(d, nul);
    check(d == memByte(0) && nul, "R6 restart", d, memByte(0));
    getFrame(d, nul);
    check(d == memByte(1), "R6 follow-on", d, memByte(1));

    // R6 + R4: restart inside the synchronisation window skips it
    doReset();
    tick(l);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    repeat (3) @(negedge clk);
    getFrame(d, nul);
    check(d == memByte(0) && nul, "R6 warmup skip", d, memByte(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule